// File: doc/BRIEF.md
# Debug Access Security Gate

This block stands between a debugger's register port and the chip's debug resources. It limits what the debugger can reach while the device is locked. Two 2-bit fields come from nonvolatile configuration and are captured on a load strobe. One is the lock field: the device is open only when it holds binary 10. The other is the erase-permission field: when it holds binary 10, erase from the debug side is forbidden.

The debugger issues one register access per cycle. Two addresses are local to the gate and are always reachable: a status word and an erase control word. Every other address is forwarded to the system bus and core debug logic. Forwarding happens only while the device is open. While locked, such an access never leaves the gate, and it returns an error with zero data.

Writing the erase bit starts a chip-wide erase request toward the flash controller. That request is held until the controller acknowledges completion. A completed erase reopens the device. An erase attempt made while erase is forbidden is refused and leaves a sticky flag that the debugger can clear. Responses come back one cycle after the request.

Top module: `dbg_access_gate`

## Requirements
- R1: After reset the lock field holds 11 and the erase-permission field holds 11, so the device is locked and erase is allowed. A cycle with `cfgLoad` high captures `cfgSec` and `cfgEraseEn`. The device counts as locked whenever the lock field differs from 10.
- R2: While locked, a request to any address of 2 or above keeps `fwdValid` low, and `fwdAddr` and `fwdWdata` stay zero. Its response has `rspErr` = 1 and `rspData` = 0.
- R3: While open, a request to an address of 2 or above raises `fwdValid` in the same cycle and passes the address, write flag and write data. Its response carries `fwdErr` as the error. On a read it carries `fwdRdata` as the data; on a write the data is 0.
- R4: A read of address 0 is answered in every lock state with `rspErr` = 0. Bit 0 is locked, bit 1 is erase pending, bit 2 is erase refused (sticky), bit 3 is erase forbidden (field equals 10), and all other bits are 0.
- R5: Writing address 1 with bit 0 set, while no erase is pending and erase is allowed, raises `eraseReq` from the next cycle. `eraseReq` then stays high until a cycle with `eraseDone`. A read of address 1 returns the pending state in bit 0 and zero elsewhere.
- R6: When the erase-permission field equals 10, a write of bit 0 of address 1 leaves `eraseReq` low and sets the sticky erase-refused bit.
- R7: Writing address 0 with bit 2 set clears the erase-refused bit. A write to address 0 with bit 2 clear leaves it unchanged.
- R8: `eraseDone` while an erase is pending drops `eraseReq` on the next cycle and sets the lock field to 10. This takes precedence over a `cfgLoad` in the same cycle. `eraseDone` with no erase pending has no effect.
- R9: An erase write to address 1 while an erase is pending has no effect: no restart and no refusal flag.
- R10: `rspValid` is high exactly in the cycle after each request. Writes to addresses 0 and 1 answer with `rspErr` = 0 and `rspData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Capture the configuration fields |
| cfgSec | input | 2 | Lock field from configuration |
| cfgEraseEn | input | 2 | Erase-permission field from configuration |
| regValid | input | 1 | Debugger request strobe |
| regWrite | input | 1 | Request is a write |
| regAddr | input | ADDR_W | Request address |
| regWdata | input | DATA_W | Request write data |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspErr | output | 1 | Response error |
| rspData | output | DATA_W | Response read data |
| fwdValid | output | 1 | Forwarded request to debug resources |
| fwdWrite | output | 1 | Forwarded write flag |
| fwdAddr | output | ADDR_W | Forwarded address, zero when not forwarding |
| fwdWdata | output | DATA_W | Forwarded write data, zero when not forwarding |
| fwdRdata | input | DATA_W | Read data from debug resources, same cycle |
| fwdErr | input | 1 | Error from debug resources, same cycle |
| eraseReq | output | 1 | Mass-erase request to flash controller |
| eraseDone | input | 1 | Erase completion acknowledge |

## Verification
Erase completion can land in the same cycle as a configuration load. It can also land in the same cycle as a forwarded access that is still judged against the old lock state. The bench pairs `eraseDone` with `cfgLoad` carrying a locked code, then expects the device to be open. It also issues a forwarded read in the completion cycle, expects a denial, and expects the next read to pass. Random traffic raises `eraseDone`, `cfgLoad` and register accesses independently, so these coincidences recur. A bench model resolves each one with erase reload ahead of configuration load.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int STS_SECURE   = 0;
  localparam int STS_BUSY     = 1;
  localparam int STS_BLOCKED  = 2;
  localparam int STS_DISABLED = 3;
  localparam int CTL_ERASE    = 0;

  localparam logic [1:0] OPEN_CODE      = 2'b10;
  localparam logic [1:0] ERASE_OFF_CODE = 2'b10;
  localparam logic [1:0] SEC_RESET      = 2'b11;
  localparam logic [1:0] ERASE_EN_RESET = 2'b11;

  typedef enum logic {ERS_IDLE, ERS_BUSY} eraseState_e;

  typedef struct packed {
    logic take;
    logic deny;
    logic fwdRd;
    logic fwdWr;
    logic rdStatus;
    logic rdCtrl;
    logic setBlocked;
    logic clrBlocked;
  } gateStrobe_t;
endpackage

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
  import dbg_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgSec,
  input  logic [1:0]        cfgEraseEn,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              eraseDone,
  output gateStrobe_t       strb,
  output logic              secure,
  output logic              eraseDis,
  output logic              erasePend,
  output logic              fwdValid
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;
  localparam logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'(1);

  logic [1:0]  secReg;
  logic [1:0]  eraseEnReg;
  eraseState_e state;
  eraseState_e stateNext;

  logic isStatus, isCtrl, isFwd;
  logic eraseWr, startErase, blockErase, finishErase;

  assign isStatus = (regAddr == STATUS_ADDR);
  assign isCtrl   = (regAddr == CTRL_ADDR);
  assign isFwd    = !isStatus && !isCtrl;

  assign secure    = (secReg != OPEN_CODE);
  assign eraseDis  = (eraseEnReg == ERASE_OFF_CODE);
  assign erasePend = (state == ERS_BUSY);

  assign eraseWr     = regValid && regWrite && isCtrl && regWdata[CTL_ERASE] && !erasePend;
  assign startErase  = eraseWr && !eraseDis;
  assign blockErase  = eraseWr && eraseDis;
  assign finishErase = erasePend && eraseDone;

  always_comb begin
    stateNext = state;
    unique case (state)
      ERS_IDLE: if (startErase)  stateNext = ERS_BUSY;
      ERS_BUSY: if (finishErase) stateNext = ERS_IDLE;
      default:                   stateNext = ERS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ERS_IDLE;
      secReg     <= SEC_RESET;
      eraseEnReg <= ERASE_EN_RESET;
    end else begin
      state <= stateNext;
      if (finishErase)  secReg <= OPEN_CODE;
      else if (cfgLoad) secReg <= cfgSec;
      if (cfgLoad) eraseEnReg <= cfgEraseEn;
    end
  end

  always_comb begin
    strb            = '0;
    strb.take       = regValid;
    strb.deny       = regValid && isFwd && secure;
    strb.fwdRd      = regValid && isFwd && !secure && !regWrite;
    strb.fwdWr      = regValid && isFwd && !secure && regWrite;
    strb.rdStatus   = regValid && isStatus && !regWrite;
    strb.rdCtrl     = regValid && isCtrl && !regWrite;
    strb.setBlocked = blockErase;
    strb.clrBlocked = regValid && regWrite && isStatus && regWdata[STS_BLOCKED];
  end

  assign fwdValid = strb.fwdRd || strb.fwdWr;

  // R5: a pending erase request persists until acknowledged
  assert_erase_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    erasePend && !eraseDone |=> erasePend);

  // R8: completion reopens the device and drops the request
  assert_unlock_after_erase_R8: assert property (@(posedge clk) disable iff (!rstN)
    erasePend && eraseDone |=> (secReg == OPEN_CODE) && !erasePend);

  // R6: an erase never starts while forbidden
  assert_no_erase_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(erasePend) |-> $past(eraseEnReg) != ERASE_OFF_CODE);

  // R1: the configuration load reaches the permission field
  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> eraseEnReg == $past(cfgEraseEn));
endmodule

// File: rtl/dbg_gate_dp.sv
module dbg_gate_dp
  import dbg_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strb,
  input  logic              secure,
  input  logic              eraseDis,
  input  logic              erasePend,
  input  logic [DATA_W-1:0] fwdRdata,
  input  logic              fwdErr,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData
);
  logic              blocked;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] dataNext;
  logic              errNext;

  always_comb begin
    statusWord               = '0;
    statusWord[STS_SECURE]   = secure;
    statusWord[STS_BUSY]     = erasePend;
    statusWord[STS_BLOCKED]  = blocked;
    statusWord[STS_DISABLED] = eraseDis;
    ctrlWord                 = '0;
    ctrlWord[CTL_ERASE]      = erasePend;
  end

  always_comb begin
    dataNext = '0;
    if (strb.fwdRd)         dataNext = fwdRdata;
    else if (strb.rdStatus) dataNext = statusWord;
    else if (strb.rdCtrl)   dataNext = ctrlWord;
    errNext = strb.deny || ((strb.fwdRd || strb.fwdWr) && fwdErr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blocked  <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.setBlocked)      blocked <= 1'b1;
      else if (strb.clrBlocked) blocked <= 1'b0;
      rspValid <= strb.take;
      rspErr   <= errNext;
      rspData  <= dataNext;
    end
  end

  // R6: the refusal flag stays until explicitly cleared
  assert_blocked_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    blocked && !strb.clrBlocked |=> blocked);

  // R2: a denied access answers with error and zero data
  assert_deny_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.deny |=> rspValid && rspErr && (rspData == '0));

  // R10: one response for each request, one cycle later
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> rspValid);
  assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> !rspValid);
endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
  import dbg_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [1:0]        cfgSec,
  input  logic [1:0]        cfgEraseEn,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic              fwdValid,
  output logic              fwdWrite,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdWdata,
  input  logic [DATA_W-1:0] fwdRdata,
  input  logic              fwdErr,
  output logic              eraseReq,
  input  logic              eraseDone
);
  gateStrobe_t strb;
  logic secure, eraseDis, erasePend;

  dbg_gate_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSec(cfgSec),
    .cfgEraseEn(cfgEraseEn), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .eraseDone(eraseDone),
    .strb(strb), .secure(secure), .eraseDis(eraseDis),
    .erasePend(erasePend), .fwdValid(fwdValid)
  );

  dbg_gate_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .secure(secure),
    .eraseDis(eraseDis), .erasePend(erasePend), .fwdRdata(fwdRdata),
    .fwdErr(fwdErr), .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData)
  );

  assign fwdWrite = fwdValid && regWrite;
  assign fwdAddr  = fwdValid ? regAddr : '0;
  assign fwdWdata = fwdValid ? regWdata : '0;
  assign eraseReq = erasePend;
endmodule

// File: tb/dbg_access_gate_bench.sv
`timescale 1ns/1ps
module dbg_access_gate_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 0, regValid = 0, regWrite = 0, eraseDone = 0, fwdErr = 0;
  logic [1:0] cfgSec = 0, cfgEraseEn = 0;
  logic [AW-1:0] regAddr = 0;
  logic [DW-1:0] regWdata = 0, fwdRdata = 0;
  logic rspValid, rspErr, fwdValid, fwdWrite, eraseReq;
  logic [DW-1:0] rspData, fwdWdata;
  logic [AW-1:0] fwdAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [1:0] mSec, mEn;
  logic mPend, mBlk;

  always #2 clk = ~clk;

  dbg_access_gate #(.ADDR_W(AW), .DATA_W(DW)) u_dbg_access_gate (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSec(cfgSec),
    .cfgEraseEn(cfgEraseEn), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .fwdValid(fwdValid),
    .fwdWrite(fwdWrite), .fwdAddr(fwdAddr), .fwdWdata(fwdWdata),
    .fwdRdata(fwdRdata), .fwdErr(fwdErr), .eraseReq(eraseReq),
    .eraseDone(eraseDone)
  );

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] statusExp();
    logic [DW-1:0] s = '0;
    s[0] = (mSec != 2'b10);
    s[1] = mPend;
    s[2] = mBlk;
    s[3] = (mEn == 2'b10);
    return s;
  endfunction

  task automatic step(input string tag, input logic ld, input logic [1:0] ls,
                      input logic [1:0] le, input logic v, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic dn, input logic [DW-1:0] frd, input logic fe);
    logic sec, dis, fwd, expErr, eraseWr, fin;
    logic [DW-1:0] expData;
    sec = (mSec != 2'b10);
    dis = (mEn == 2'b10);
    fwd = v && (a >= 2) && !sec;
    expErr = 1'b0;
    expData = '0;
    if (v) begin
      if (a == 0) begin
        if (!w) expData = statusExp();
      end else if (a == 1) begin
        if (!w) expData = {{(DW-1){1'b0}}, mPend};
      end else if (sec) begin
        expErr = 1'b1;
      end else begin
        expErr = fe;
        if (!w) expData = frd;
      end
    end
    @(negedge clk);
    cfgLoad = ld; cfgSec = ls; cfgEraseEn = le;
    regValid = v; regWrite = w; regAddr = a; regWdata = d;
    eraseDone = dn; fwdRdata = frd; fwdErr = fe;
    #1;
    check(tag, "fwdValid", DW'(fwdValid), DW'(fwd));
    check(tag, "fwdAddr", DW'(fwdAddr), fwd ? DW'(a) : '0);
    check(tag, "fwdWdata", fwdWdata, fwd ? d : '0);
    @(posedge clk);
    #1;
    eraseWr = v && w && (a == 1) && d[0] && !mPend;
    fin = dn && mPend;
    if (eraseWr && dis) mBlk = 1'b1;
    else if (v && w && (a == 0) && d[2]) mBlk = 1'b0;
    if (fin) mPend = 1'b0;
    else if (eraseWr && !dis) mPend = 1'b1;
    if (fin) mSec = 2'b10;
    else if (ld) mSec = ls;
    if (ld) mEn = le;
    check("R10", "rspValid", DW'(rspValid), DW'(v));
    if (v) begin
      check(tag, "rspErr", DW'(rspErr), DW'(expErr));
      check(tag, "rspData", rspData, expData);
    end
    check(tag, "eraseReq", DW'(eraseReq), DW'(mPend));
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    step(tag, 0, 2'b00, 2'b00, 1, 0, a, '0, 0, 32'hA5A5_0000 | DW'(a), 0);
  endtask
  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(tag, 0, 2'b00, 2'b00, 1, 1, a, d, 0, '0, 0);
  endtask
  task automatic load(input string tag, input logic [1:0] ls, input logic [1:0] le);
    step(tag, 1, ls, le, 0, 0, '0, '0, 0, '0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog run hung actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd20240611);
    mSec = 2'b11; mEn = 2'b11; mPend = 0; mBlk = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset rspValid", DW'(rspValid), '0);
    check("R1", "reset eraseReq", DW'(eraseReq), '0);
    check("R1", "reset fwdValid", DW'(fwdValid), '0);
    @(negedge clk);
    rstN = 1'b1;
    rd("R1", 8'd0);                        // locked after reset
    rd("R2", 8'd7);                        // denied read
    wr("R2", 8'd200, 32'hDEAD_BEEF);       // denied write
    load("R1", 2'b10, 2'b11);              // open
    rd("R3", 8'd9);
    step("R3", 0, 2'b00, 2'b00, 1, 1, 8'd40, 32'h1234_5678, 0, '0, 1);
    rd("R4", 8'd0);
    load("R1", 2'b00, 2'b10);              // locked, erase forbidden
    wr("R6", 8'd1, 32'h1);
    rd("R6", 8'd0);
    wr("R7", 8'd0, 32'hFFFF_FFFB);         // bit 2 clear: keeps flag
    rd("R7", 8'd0);
    wr("R7", 8'd0, 32'h4);                 // clears flag
    rd("R7", 8'd0);
    load("R1", 2'b01, 2'b11);              // erase allowed
    wr("R5", 8'd1, 32'h1);
    rd("R5", 8'd1);
    rd("R5", 8'd0);
    wr("R9", 8'd1, 32'h1);                 // ignored while pending
    load("R9", 2'b01, 2'b10);
    wr("R9", 8'd1, 32'h1);                 // pending: no refusal flag
    rd("R9", 8'd0);
    // completion with locked cfgLoad and a forwarded read in the same cycle
    step("R8", 1, 2'b00, 2'b11, 1, 0, 8'd33, '0, 1, 32'h5555_AAAA, 0);
    rd("R8", 8'd33);                       // now open
    rd("R8", 8'd0);
    step("R8", 0, 2'b00, 2'b00, 0, 0, '0, '0, 1, '0, 0); // stray done ignored
    rd("R8", 8'd0);

    for (int i = 0; i < 3000; i++) begin
      logic ld, v, w, dn, fe;
      logic [1:0] ls, le;
      logic [AW-1:0] a;
      logic [DW-1:0] d, frd;
      int unsigned r;
      string tag;
      ld = ($urandom % 16) == 0;
      ls = ($urandom % 2) ? 2'b10 : 2'($urandom);
      le = ($urandom % 3 == 0) ? 2'b10 : 2'($urandom);
      v = ($urandom % 4) != 0;
      w = $urandom % 2;
      r = $urandom % 8;
      a = (r < 3) ? 8'd0 : (r < 5) ? 8'd1 : AW'(2 + ($urandom % 250));
      d = $urandom;
      if (a == 1 && ($urandom % 2)) d[0] = 1'b1;
      if (a == 0 && ($urandom % 2)) d[2] = 1'b0;
      dn = ($urandom % 5) == 0;
      frd = $urandom;
      fe = ($urandom % 6) == 0;
      if (a == 0) tag = w ? "R7" : "R4";
      else if (a == 1) tag = (mEn == 2'b10) ? "R6" : "R5";
      else tag = (mSec != 2'b10) ? "R2" : "R3";
      step(tag, ld, ls, le, v, w, a, d, dn, frd, fe);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule